// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the slave side of a two-wire serial bus (I2C) for a small byte-wide non-volatile memory. It holds a 1024 x 8 storage array. A fast system clock samples the bus clock and data lines and follows the protocol. SDA is driven through a single pull-low enable, and the board or bench supplies the pull-up.

Each transaction begins with a start condition. The first byte is the selection byte. It carries a fixed four-bit device code, one bit that is compared with a strap input, two bits that choose one of four 256-byte pages, and the direction bit. A write-direction transaction loads a word address and may then store data bytes. A read-direction transaction returns bytes from an internal pointer. Combining a write-direction address phase with a repeated start and a read gives random access. Acknowledging each returned byte streams further bytes. The pointer advances after every byte and wraps around the full array.

The protocol engine sees SCL and SDA only through synchronizers with edge detection. It changes its SDA drive only while SCL is low. A repeated start takes effect at any moment, and a stop ends any transaction.

Top module: `twowire_eeprom`

## Requirements
- R1: A stop (SDA rising while SCL is high) returns the block to idle with SDA released. In idle, and after reset, no clock pulse is acknowledged until a start (SDA falling while SCL is high) is seen.
- R2: The selection byte is received MSB first. Bits 7:4 must be 1010 and bit 3 must equal the strap input, or the slave gives no acknowledge and ignores the bus until the next start.
- R3: In a write-direction transaction, the byte after the selection byte sets the pointer to {selection bits 2:1, byte}. Each following byte is stored at the pointer, and the pointer then increments.
- R4: A random read (write-direction selection, word address, repeated start, read-direction selection) returns the byte stored at that word address.
- R5: A read-direction selection with no address phase returns the byte at the pointer left by the previous access.
- R6: When the master acknowledges a read byte, the next byte follows. The pointer wraps from 1023 to 0.
- R7: When the master does not acknowledge a read byte, the slave releases SDA and ignores the bus until a start or stop.
- R8: A start received in the middle of a byte abandons that byte and restarts reception of the selection byte.
- R9: After reset SDA is released, and the slave begins pulling SDA low only while SCL is low.
- R10: The slave acknowledges by holding SDA low for the whole ninth clock pulse after a matching selection byte, the word-address byte and each write-data byte. Read bytes are sent MSB first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired level) |
| strap_a2_i | input | 1 | Strap value compared with selection bit 3 |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
Most wrong internal states show up on SDA within one byte frame. A wrong bit counter or state moves or drops the acknowledge on the ninth pulse. A wrong pointer returns the wrong byte on the next read, so every write is read back, and the pointer is followed across page boundaries and the wrap from 1023 to 0. A slave that fails to leave a rejected or non-acknowledged transaction is caught on the next pulse, because it drives SDA when it should stay silent.

// File: rtl/tw_pkg.sv
package tw_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } tw_state_e;
endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    // chain_q[STAGES-1] is the synchronized level, chain_q[STAGES] the level one cycle earlier
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-1:0], line_i};
    end

    assign level_o = chain_q[STAGES-1];
    assign rise_o  =  chain_q[STAGES-1] & ~chain_q[STAGES];
    assign fall_o  = ~chain_q[STAGES-1] &  chain_q[STAGES];
endmodule

// File: rtl/tw_mem.sv
module tw_mem #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells_q[waddr] <= wdata;
    end

    assign rdata = cells_q[raddr];
endmodule

// File: rtl/twowire_eeprom.sv
module twowire_eeprom
    import tw_pkg::*;
#(
    parameter logic [3:0] DEV_CODE    = 4'b1010,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic strap_a2_i,
    output logic sda_pull_o
);
    localparam int PAGE_W = 2;
    localparam int DATA_W = 8;
    localparam int ADDR_W = DATA_W + PAGE_W;
    localparam int CNT_W  = $clog2(DATA_W) + 1;

    typedef struct packed {
        tw_state_e          st;
        logic [CNT_W-1:0]   cnt;
        logic [DATA_W-1:0]  sh;
        logic               rw;
        logic [PAGE_W-1:0]  page;
        logic [ADDR_W-1:0]  ptr;
        logic               pull;
        logic               mack;
    } regs_t;

    localparam logic [CNT_W-1:0] BYTE_END = CNT_W'(DATA_W);

    logic scl_lvl, scl_rise, scl_fall;
    logic sda_lvl, sda_rise, sda_fall;
    logic start_evt, stop_evt;
    logic we;
    logic [DATA_W-1:0] rdata;
    regs_t r_d, r_q;

    tw_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .line_i(scl_i),
        .level_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall)
    );

    tw_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .line_i(sda_i),
        .level_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall)
    );

    tw_mem #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
        .clk(clk), .we(we), .waddr(r_q.ptr), .wdata(r_q.sh),
        .raddr(r_q.ptr), .rdata(rdata)
    );

    assign start_evt = sda_fall & scl_lvl;
    assign stop_evt  = sda_rise & scl_lvl;

    always_comb begin
        r_d = r_q;
        we  = 1'b0;
        case (r_q.st)
            ST_DEV, ST_WADDR, ST_WDATA: begin
                if (scl_rise && r_q.cnt < BYTE_END) begin
                    r_d.sh  = {r_q.sh[DATA_W-2:0], sda_lvl};
                    r_d.cnt = r_q.cnt + CNT_W'(1);
                end else if (scl_fall && r_q.cnt == BYTE_END) begin
                    r_d.cnt = '0;
                    if (r_q.st == ST_DEV) begin
                        if (r_q.sh[7:4] == DEV_CODE && r_q.sh[3] == strap_a2_i) begin
                            r_d.rw   = r_q.sh[0];
                            r_d.page = r_q.sh[2:1];
                            r_d.pull = 1'b1;
                            r_d.st   = ST_DEV_ACK;
                        end else begin
                            r_d.st = ST_IGNORE;
                        end
                    end else if (r_q.st == ST_WADDR) begin
                        r_d.ptr  = {r_q.page, r_q.sh};
                        r_d.pull = 1'b1;
                        r_d.st   = ST_WADDR_ACK;
                    end else begin
                        we       = 1'b1;
                        r_d.ptr  = r_q.ptr + ADDR_W'(1);
                        r_d.pull = 1'b1;
                        r_d.st   = ST_WACK;
                    end
                end
            end
            ST_DEV_ACK, ST_WADDR_ACK, ST_WACK: begin
                if (scl_fall) begin
                    r_d.pull = 1'b0;
                    r_d.cnt  = '0;
                    if (r_q.st == ST_DEV_ACK && r_q.rw) begin
                        r_d.sh   = rdata;
                        r_d.pull = ~rdata[DATA_W-1];
                        r_d.cnt  = CNT_W'(1);
                        r_d.ptr  = r_q.ptr + ADDR_W'(1);
                        r_d.st   = ST_RDATA;
                    end else if (r_q.st == ST_DEV_ACK) begin
                        r_d.st = ST_WADDR;
                    end else begin
                        r_d.st = ST_WDATA;
                    end
                end
            end
            ST_RDATA: begin
                if (scl_fall) begin
                    if (r_q.cnt < BYTE_END) begin
                        r_d.sh   = {r_q.sh[DATA_W-2:0], 1'b0};
                        r_d.pull = ~r_q.sh[DATA_W-2];
                        r_d.cnt  = r_q.cnt + CNT_W'(1);
                    end else begin
                        r_d.pull = 1'b0;
                        r_d.st   = ST_RACK;
                    end
                end
            end
            ST_RACK: begin
                if (scl_rise) begin
                    r_d.mack = sda_lvl;
                end else if (scl_fall) begin
                    if (!r_q.mack) begin
                        r_d.sh   = rdata;
                        r_d.pull = ~rdata[DATA_W-1];
                        r_d.cnt  = CNT_W'(1);
                        r_d.ptr  = r_q.ptr + ADDR_W'(1);
                        r_d.st   = ST_RDATA;
                    end else begin
                        r_d.pull = 1'b0;
                        r_d.st   = ST_IGNORE;
                    end
                end
            end
            default: ;
        endcase

        if (start_evt) begin
            r_d.st   = ST_DEV;
            r_d.cnt  = '0;
            r_d.pull = 1'b0;
        end else if (stop_evt) begin
            r_d.st   = ST_IDLE;
            r_d.cnt  = '0;
            r_d.pull = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, cnt: '0, sh: '0, rw: 1'b0, page: '0,
                     ptr: '0, pull: 1'b0, mack: 1'b1};
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_pull_o = r_q.pull;

    p_pull_rise_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.pull) |-> !$past(scl_lvl));

    p_start_rearms_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> (r_q.st == ST_DEV && r_q.cnt == '0 && !r_q.pull));

    p_stop_idles_r1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> (r_q.st == ST_IDLE && !r_q.pull));

    p_silent_when_passive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE || r_q.st == ST_IGNORE) |-> !r_q.pull);

    p_store_then_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (r_q.st == ST_WACK && r_q.pull));
endmodule

// File: tb/twowire_eeprom_test.sv
module twowire_eeprom_test;
    localparam int Q = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic strap = 1'b1;
    logic sda_pull;
    logic sda_bus;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [7:0] model [1024];
    int mptr = 0;

    logic [7:0] exp_v [$];
    string      exp_t [$];
    logic [7:0] got_v;
    event       got_ev;

    always #10 clk = ~clk;

    assign sda_bus = sda_m & ~sda_pull;

    twowire_eeprom uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
        .strap_a2_i(strap), .sda_pull_o(sda_pull)
    );

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    // monitor: pairs each received byte with the oldest expected one
    initial begin
        forever begin
            @(got_ev);
            tests++;
            if (exp_v.size() == 0) begin
                fails++;
                $display("FAIL R4 unexpected byte: got %0h expected none", got_v);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_v.pop_front();
                t = exp_t.pop_front();
                if (got_v !== e) begin
                    fails++;
                    $display("FAIL %s: got %0h expected %0h", t, got_v, e);
                end
            end
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clock_bit(input logic b, output logic seen);
        sda_m = b;
        wait_clk(2 * Q);
        scl = 1'b1;
        wait_clk(Q);
        seen = sda_bus;
        wait_clk(Q);
        scl = 1'b0;
        wait_clk(Q);
    endtask

    task automatic bus_start();
        sda_m = 1'b1;
        wait_clk(Q);
        scl = 1'b1;
        wait_clk(Q);
        sda_m = 1'b0;
        wait_clk(Q);
        scl = 1'b0;
        wait_clk(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0;
        wait_clk(Q);
        scl = 1'b1;
        wait_clk(Q);
        sda_m = 1'b1;
        wait_clk(2 * Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
        clock_bit(1'b1, s);
        acked = !s;
    endtask

    task automatic recv_byte(input logic give_ack, input string tag, input logic [7:0] expv);
        logic s;
        logic [7:0] d = '0;
        exp_v.push_back(expv);
        exp_t.push_back(tag);
        for (int i = 0; i < 8; i++) begin
            clock_bit(1'b1, s);
            d = {d[6:0], s};
        end
        got_v = d;
        -> got_ev;
        clock_bit(!give_ack, s);
    endtask

    function automatic logic [7:0] sel(input logic [1:0] page, input logic rd);
        return {4'b1010, strap, page, rd};
    endfunction

    task automatic write_byte(input int addr, input logic [7:0] data);
        logic a;
        bus_start();
        send_byte(sel(addr[9:8], 1'b0), a);
        chk("R2 R10 selection ack on write", a, 1);
        send_byte(addr[7:0], a);
        chk("R3 R10 word address ack", a, 1);
        send_byte(data, a);
        chk("R3 R10 write data ack", a, 1);
        bus_stop();
        model[addr] = data;
        mptr = (addr + 1) % 1024;
    endtask

    task automatic random_read(input int addr, input int n, input string tag);
        logic a;
        bus_start();
        send_byte(sel(addr[9:8], 1'b0), a);
        chk("R4 dummy write selection ack", a, 1);
        send_byte(addr[7:0], a);
        chk("R4 dummy write address ack", a, 1);
        bus_start();
        send_byte(sel(addr[9:8], 1'b1), a);
        chk("R4 read selection ack", a, 1);
        for (int i = 0; i < n; i++)
            recv_byte(i < n - 1, tag, model[(addr + i) % 1024]);
        bus_stop();
        mptr = (addr + n) % 1024;
    endtask

    task automatic current_read(input int n, input string tag);
        logic a;
        bus_start();
        send_byte(sel(2'b00, 1'b1), a);
        chk("R5 current read selection ack", a, 1);
        for (int i = 0; i < n; i++)
            recv_byte(i < n - 1, tag, model[(mptr + i) % 1024]);
        bus_stop();
        mptr = (mptr + n) % 1024;
    endtask

    initial begin
        logic a;
        logic s;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        chk("R9 SDA released after reset", sda_pull, 0);

        // R1: clock a selection byte with no start first
        scl = 1'b0;
        wait_clk(Q);
        send_byte(sel(2'b00, 1'b0), a);
        chk("R1 no ack without start", a, 0);
        bus_stop();

        write_byte(10'h005, 8'hA5);
        write_byte(10'h006, 8'h5A);
        write_byte(10'h2FF, 8'h3C);
        write_byte(10'h200, 8'hC3);
        write_byte(10'h0FF, 8'h11);
        write_byte(10'h3FF, 8'h7E);
        write_byte(10'h000, 8'h81);

        random_read(10'h005, 2, "R4 R6 random then sequential");
        random_read(10'h2FF, 1, "R3 page bits select upper page");
        random_read(10'h0FF, 1, "R3 page zero distinct from page two");
        random_read(10'h200, 1, "R3 R10 page two first byte");
        random_read(10'h3FF, 1, "R6 last location");
        current_read(1, "R5 R6 pointer wrapped to zero");
        random_read(10'h3FF, 2, "R6 sequential wrap 1023 to 0");

        // R2: wrong device code, then further bytes must not be stored
        bus_start();
        send_byte(8'b1011_1000, a);
        chk("R2 wrong device code not acked", a, 0);
        send_byte(8'h05, a);
        chk("R2 ignored until start", a, 0);
        send_byte(8'hFF, a);
        chk("R2 ignored data byte", a, 0);
        bus_stop();
        random_read(10'h005, 1, "R2 memory untouched by rejected access");

        // R2: strap mismatch
        bus_start();
        send_byte({4'b1010, ~strap, 2'b00, 1'b0}, a);
        chk("R2 strap mismatch not acked", a, 0);
        bus_stop();

        // R8: repeated start in the middle of the word-address byte
        bus_start();
        send_byte(sel(2'b00, 1'b0), a);
        chk("R8 selection ack before abort", a, 1);
        for (int i = 0; i < 4; i++) clock_bit(1'b0, s);
        bus_start();
        send_byte(sel(2'b00, 1'b1), a);
        chk("R8 selection after repeated start acked", a, 1);
        recv_byte(1'b0, "R8 R5 pointer kept after aborted byte", model[mptr]);
        mptr = (mptr + 1) % 1024;

        // R7: after master NACK the slave stays silent until start/stop
        clock_bit(1'b1, s);
        chk("R7 SDA released after master NACK", s, 1);
        send_byte(sel(2'b00, 1'b0), a);
        chk("R7 no ack while waiting for stop", a, 0);
        bus_stop();
        current_read(1, "R7 R5 pointer unchanged by ignored bytes");

        wait_clk(4 * Q);
        chk("R4 scoreboard drained", exp_v.size(), 0);
        chk("R1 SDA released when idle", sda_pull, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule